// File: doc/BRIEF.md
# Palette Pixel Format Expander

This block converts a stream of packed frame-buffer data into 24-bit RGB pixels, one pixel per output beat. It holds a 256-entry palette of 12-bit colours and reads indexed pixels of 2, 4 or 8 bits through it. It also passes 16-bit direct colour straight through, as either 4:4:4 or 5:6:5. Input beats and output pixels each use a valid/ready handshake. A separate write port fills the palette.

The active format is not held in a control register. It is taken from bits 14:12 of palette entry 0. The low 12 bits of that entry still act as the colour for index 0. A panel-type input picks how a 16-bit word is read. A line-length input, counted in pixels, marks the last pixel of each line. When a line ends part way through a packed byte, the pixels left in that byte are dropped.

Top module: `pal_pixel_expander`

## Requirements
- R1: After reset, `out_valid_o` is low, and no pixel leaves the block until a beat has been accepted and expanded.
- R2: While format code 0 (bits 14:12 of palette entry 0) is in force, `in_ready_o` stays low and no pixel is produced.
- R3: Code 1 selects 2 bits per pixel. Each byte gives four palette indices in the order bits 1:0, 3:2, 5:4, 7:6.
- R4: Code 2 selects 4 bits per pixel. Each byte gives its low nibble first, then its high nibble.
- R5: Code 3 selects 8 bits per pixel. Each byte is one palette index in the range 0 to 255.
- R6: A palette colour (red in bits 11:8, green in 7:4, blue in 3:0) is output as `{R,4'h0,G,4'h0,B,4'h0}` on `out_rgb_o[23:0]`.
- R7: Codes 4 to 7 with `tft_i`=0 take `in_data_i` as a little-endian 16-bit word (low byte in bits 7:0) and expand its bits 11:0 in the same way as a palette colour.
- R8: Codes 4 to 7 with `tft_i`=1 expand the word as 5:6:5, giving `{w[15:11],3'b0,w[10:5],2'b0,w[4:0],3'b0}`.
- R9: `out_last_o` marks pixel number `line_len_i` of each line. In packed modes, a byte that crosses the line end gives only the pixels still needed, and the next byte starts a new line.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_rgb_o` and `out_last_o` hold their values.
- R11: A palette lookup made in the same cycle as a write to that index returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tft_i | input | 1 | 16-bit word layout: 0 = 4:4:4, 1 = 5:6:5 |
| line_len_i | input | 11 | Pixels per line, 1 or more |
| pal_we_i | input | 1 | Palette write strobe |
| pal_widx_i | input | 8 | Palette write index |
| pal_wdata_i | input | 16 | Palette write entry |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | 16 | Input beat: a byte in bits 7:0, or a 16-bit word |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| out_valid_o | output | 1 | Output pixel valid |
| out_rgb_o | output | 24 | Pixel as R[23:16], G[15:8], B[7:0] |
| out_last_o | output | 1 | Last pixel of a line |
| out_ready_i | input | 1 | Downstream accepts the pixel |

## Verification
Bytes such as 0xE4 and 0x1B put a different index in every 2-bit slot, so an error in slot order or shift direction changes the colours that come out. Nibble pairs like 0x21 show whether the low nibble leaves first. The byte values 0x00, 0xFF, 0x80 and 0x7F hit the ends of the palette and its top index bit. For the direct-colour modes, the words 0xF800, 0x07E0 and 0x001F each drive one 5:6:5 channel alone, which exposes any channel that is swapped or shifted wrongly. Line lengths that stop part way through a byte, a stretch of pseudo-random backpressure, and a palette write timed to land on the very cycle its index is looked up cover the corner cases.

// File: rtl/pal_fmt_pkg.sv
package pal_fmt_pkg;

  localparam int FMT_LSB = 12;

  typedef enum logic [2:0] {
    FM_OFF  = 3'd0,
    FM_2    = 3'd1,
    FM_4    = 3'd2,
    FM_8    = 3'd3,
    FM_444D = 3'd4,
    FM_565D = 3'd5
  } fmt_e;

  // map the code field of entry 0 plus the panel type onto a format
  function automatic fmt_e decode_fmt(input logic [2:0] code, input logic tft);
    fmt_e f;
    case (code)
      3'd0:    f = FM_OFF;
      3'd1:    f = FM_2;
      3'd2:    f = FM_4;
      3'd3:    f = FM_8;
      default: f = tft ? FM_565D : FM_444D;
    endcase
    return f;
  endfunction

  function automatic logic is_direct(input fmt_e f);
    return (f == FM_444D) || (f == FM_565D);
  endfunction

  // pixels carried by one input beat
  function automatic logic [2:0] beat_pixels(input fmt_e f);
    logic [2:0] n;
    case (f)
      FM_2:    n = 3'd4;
      FM_4:    n = 3'd2;
      default: n = 3'd1;
    endcase
    return n;
  endfunction

  // palette index held in a slot, least significant slot first
  function automatic logic [7:0] slot_index(input fmt_e f, input logic [7:0] b,
                                            input logic [1:0] slot);
    logic [7:0] sh;
    logic [7:0] idx;
    case (f)
      FM_2: begin
        sh  = b >> {slot, 1'b0};
        idx = {6'd0, sh[1:0]};
      end
      FM_4: begin
        sh  = b >> {slot[0], 2'b00};
        idx = {4'd0, sh[3:0]};
      end
      default: begin
        sh  = b;
        idx = sh;
      end
    endcase
    return idx;
  endfunction

  function automatic logic [23:0] widen_444(input logic [11:0] c);
    return {c[11:8], 4'h0, c[7:4], 4'h0, c[3:0], 4'h0};
  endfunction

  function automatic logic [23:0] widen_565(input logic [15:0] w);
    return {w[15:11], 3'b000, w[10:5], 2'b00, w[4:0], 3'b000};
  endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int CW  = 12,
  parameter int FLS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [CW-1:0] rcolour,
  output logic [2:0]    ent0_code
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // the read path sees the array before this cycle's write lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rcolour   = mem[ridx][CW-1:0];
  assign ent0_code = mem[0][FLS+2:FLS];

endmodule

// File: rtl/beat_unpacker.sv
module beat_unpacker
  import pal_fmt_pkg::*;
#(
  parameter int BW    = 16,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic [LEN_W-1:0] line_len,
  input  logic             in_valid,
  input  logic [BW-1:0]    in_data,
  output logic             in_ready,
  output logic             pix_valid,
  output logic [BW-1:0]    pix_word,
  output logic             pix_last,
  input  logic             pix_ready
);
  logic             hold_v;
  logic [BW-1:0]    hold_w;
  logic [1:0]       slot;
  logic [LEN_W-1:0] cnt;

  logic       fmt_on;
  logic [2:0] per_beat;
  logic       take;
  logic       line_end;
  logic       beat_end;
  logic       accept;

  assign fmt_on    = (fmt != FM_OFF);
  assign per_beat  = beat_pixels(fmt);
  assign pix_valid = hold_v && fmt_on;
  assign take      = pix_valid && pix_ready;
  assign line_end  = ({1'b0, cnt} + 1'b1) >= {1'b0, line_len};
  assign beat_end  = line_end || ({1'b0, slot} == (per_beat - 3'd1));
  assign in_ready  = fmt_on && (!hold_v || (take && beat_end));
  assign accept    = in_valid && in_ready;
  assign pix_last  = line_end;

  always_comb begin
    if (is_direct(fmt)) pix_word = hold_w;
    else                pix_word = {{(BW-8){1'b0}}, slot_index(fmt, hold_w[7:0], slot)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_w <= '0;
      slot   <= '0;
    end else if (accept) begin
      hold_v <= 1'b1;
      hold_w <= in_data;
      slot   <= '0;
    end else if (take && beat_end) begin
      hold_v <= 1'b0;
    end else if (take) begin
      slot <= slot + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (take)    cnt <= line_end ? '0 : cnt + 1'b1;
  end

  // R9
  slot_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ({1'b0, slot} < per_beat));

  // R9
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pix_last) |=> (cnt == '0));

  // R2
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_on && !hold_v) |=> !hold_v);

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
  import pal_fmt_pkg::*;
#(
  parameter int BW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          pix_valid,
  input  logic [BW-1:0] pix_word,
  input  logic          pix_last,
  output logic          pix_ready,
  output logic [7:0]    pal_idx,
  input  logic [CW-1:0] pal_colour,
  output logic          out_valid,
  output logic [23:0]   out_rgb,
  output logic          out_last,
  input  logic          out_ready
);
  logic        take;
  logic [23:0] rgb_next;

  assign pix_ready = !out_valid || out_ready;
  assign take      = pix_valid && pix_ready;
  assign pal_idx   = pix_word[7:0];

  always_comb begin
    case (fmt)
      FM_565D: rgb_next = widen_565(pix_word);
      FM_444D: rgb_next = widen_444(pix_word[CW-1:0]);
      default: rgb_next = widen_444(pal_colour);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_last  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_rgb   <= rgb_next;
      out_last  <= pix_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_last)));

  // R1
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pix_valid));

endmodule

// File: rtl/pal_pixel_expander.sv
module pal_pixel_expander
  import pal_fmt_pkg::*;
#(
  parameter int PAL_AW = 8,
  parameter int ENT_W  = 16,
  parameter int BEAT_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tft_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_widx_i,
  input  logic [ENT_W-1:0]  pal_wdata_i,
  input  logic              in_valid_i,
  input  logic [BEAT_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [23:0]       out_rgb_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam int CW = 12;

  logic [2:0]        code;
  fmt_e              fmt;
  logic [CW-1:0]     pal_colour;
  logic [7:0]        pal_idx;
  logic              pix_valid;
  logic [BEAT_W-1:0] pix_word;
  logic              pix_last;
  logic              pix_ready;

  assign fmt = decode_fmt(code, tft_i);

  pal_store #(.AW(PAL_AW), .DW(ENT_W), .CW(CW), .FLS(FMT_LSB)) u_pal (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (pal_we_i),
    .widx      (pal_widx_i),
    .wdata     (pal_wdata_i),
    .ridx      (pal_idx[PAL_AW-1:0]),
    .rcolour   (pal_colour),
    .ent0_code (code)
  );

  beat_unpacker #(.BW(BEAT_W), .LEN_W(LEN_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .line_len  (line_len_i),
    .in_valid  (in_valid_i),
    .in_data   (in_data_i),
    .in_ready  (in_ready_o),
    .pix_valid (pix_valid),
    .pix_word  (pix_word),
    .pix_last  (pix_last),
    .pix_ready (pix_ready)
  );

  pix_out_stage #(.BW(BEAT_W), .CW(CW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (fmt),
    .pix_valid  (pix_valid),
    .pix_word   (pix_word),
    .pix_last   (pix_last),
    .pix_ready  (pix_ready),
    .pal_idx    (pal_idx),
    .pal_colour (pal_colour),
    .out_valid  (out_valid_o),
    .out_rgb    (out_rgb_o),
    .out_last   (out_last_o),
    .out_ready  (out_ready_i)
  );

  // R2
  fmt_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FM_OFF && !out_valid_o) |=> !out_valid_o);

endmodule

// File: tb/test_pal_pixel_expander.sv
module test_pal_pixel_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tft = 1'b0;
  logic [10:0] line_len = 11'd1;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_widx = '0;
  logic [15:0] pal_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic        out_last;
  logic        out_ready = 1'b1;

  always #5 clk = ~clk;

  pal_pixel_expander i_pal_pixel_expander (
    .clk(clk), .rst_n(rst_n), .tft_i(tft), .line_len_i(line_len),
    .pal_we_i(pal_we), .pal_widx_i(pal_widx), .pal_wdata_i(pal_wdata),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_rgb_o(out_rgb), .out_last_o(out_last),
    .out_ready_i(out_ready)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [24:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] pal_m [256];
  logic [15:0] beat_buf [32];
  bit          auto_bp = 0;
  logic [7:0]  lfsr = 8'h5b;
  bit          done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // colour rules restated from the requirements
  function automatic logic [23:0] m_444(logic [11:0] c);
    logic [23:0] r;
    r = 24'd0;
    r[23:20] = c[11:8];
    r[15:12] = c[7:4];
    r[7:4]   = c[3:0];
    return r;
  endfunction

  function automatic logic [23:0] m_565(logic [15:0] w);
    logic [23:0] r;
    r = 24'd0;
    r[23:19] = w[15:11];
    r[15:10] = w[10:5];
    r[7:3]   = w[4:0];
    return r;
  endfunction

  // backpressure pattern
  always @(posedge clk) begin
    if (auto_bp) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[3];
    end
  end

  // monitor: pop and compare on each accepted pixel; also watch stalls (R10)
  logic [24:0] prev_out = '0;
  bit          prev_stall = 0;
  always @(negedge clk) begin
    if (prev_stall)
      chk("R10 held output", {7'd0, out_valid, out_last, out_rgb}, {7'd0, 1'b1, prev_out});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected pixel", {7'd0, out_last, out_rgb}, 32'hffff_ffff);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {7'd0, out_last, out_rgb}, {7'd0, e});
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_out   = {out_last, out_rgb};
  end

  task automatic pal_wr(logic [7:0] idx, logic [15:0] v);
    @(posedge clk); #1;
    pal_we = 1'b1; pal_widx = idx; pal_wdata = v;
    @(posedge clk); #1;
    pal_we = 1'b0;
    pal_m[idx] = v;
  endtask

  task automatic send_beat(logic [15:0] d);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic push_exp(logic [23:0] rgb, logic last, string req);
    exp_q.push_back({last, rgb});
    tag_q.push_back(req);
  endtask

  // play nb beats from beat_buf as one or more lines of len pixels
  task automatic play(int code, int len, int nb, string req);
    int pos = 0;
    for (int b = 0; b < nb; b++) begin
      int per;
      int bits;
      per  = (code == 1) ? 4 : (code == 2) ? 2 : 1;
      bits = (code == 1) ? 2 : (code == 2) ? 4 : 8;
      for (int k = 0; k < per; k++) begin
        logic [23:0] rgb;
        logic [7:0]  idx;
        if (code >= 4) begin
          rgb = tft ? m_565(beat_buf[b]) : m_444(beat_buf[b][11:0]);
        end else begin
          idx = (beat_buf[b][7:0] >> (bits * k)) & ((1 << bits) - 1);
          rgb = m_444(pal_m[idx][11:0]);
        end
        push_exp(rgb, (pos == len - 1), req);
        if (pos == len - 1) begin
          pos = 0;
          break;
        end
        pos++;
      end
      send_beat(beat_buf[b]);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(posedge clk);
      n++;
    end
    if (exp_q.size() != 0) chk("drain timeout", exp_q.size(), 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic set_code(int code);
    pal_wr(8'd0, {1'b0, code[2:0], 12'h5a3});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) pal_m[i] = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid after reset", out_valid, 0);
    // R2 entry 0 resets to code 0, so input is refused
    chk("R2 in_ready after reset", in_ready, 0);

    // R2: offered input under code 0 is neither taken nor expanded
    begin
      bit seen = 0;
      in_valid = 1'b1; in_data = 16'h00e4;
      repeat (12) begin
        @(negedge clk);
        if (in_ready || out_valid) seen = 1;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R2 code 0 stays idle", seen, 0);
    end

    // fill the palette
    for (int i = 1; i < 256; i++) pal_wr(i[7:0], 16'((i * 149 + 7) & 12'hfff));

    // R3: 2 bpp, two full bytes
    set_code(1);
    line_len = 11'd8;
    beat_buf[0] = 16'h00e4; beat_buf[1] = 16'h001b;
    play(1, 8, 2, "R3 2bpp order");
    drain();

    // R9: 2 bpp line of 6 ends inside the second byte, then a new line of 6
    line_len = 11'd6;
    beat_buf[0] = 16'h0039; beat_buf[1] = 16'h00c6;
    beat_buf[2] = 16'h0072; beat_buf[3] = 16'h008d;
    play(1, 6, 4, "R9 2bpp partial byte");
    drain();

    // R4: 4 bpp, line of 5 ends on a low nibble
    set_code(2);
    line_len = 11'd5;
    beat_buf[0] = 16'h0021; beat_buf[1] = 16'h0043; beat_buf[2] = 16'h00f5;
    play(2, 5, 3, "R4 4bpp nibble order");
    drain();

    // R5 R6: 8 bpp palette ends and top bit
    set_code(3);
    line_len = 11'd4;
    beat_buf[0] = 16'h0000; beat_buf[1] = 16'h00ff;
    beat_buf[2] = 16'h0080; beat_buf[3] = 16'h007f;
    play(3, 4, 4, "R5 R6 8bpp lookup");
    drain();

    // R7: 16 bpp 4:4:4 under codes 4 and 7
    tft = 1'b0;
    set_code(4);
    line_len = 11'd3;
    beat_buf[0] = 16'hfabc; beat_buf[1] = 16'h0f00; beat_buf[2] = 16'h1234;
    play(4, 3, 3, "R7 code4 direct 444");
    drain();
    set_code(7);
    beat_buf[0] = 16'h00f0; beat_buf[1] = 16'h800f; beat_buf[2] = 16'h0edc;
    play(7, 3, 3, "R7 code7 direct 444");
    drain();

    // R8: 5:6:5 channels one at a time
    tft = 1'b1;
    set_code(5);
    line_len = 11'd4;
    beat_buf[0] = 16'hf800; beat_buf[1] = 16'h07e0;
    beat_buf[2] = 16'h001f; beat_buf[3] = 16'hffff;
    play(5, 4, 4, "R8 565 channels");
    drain();
    tft = 1'b0;

    // R10: 8 bpp under pseudo-random backpressure
    set_code(3);
    line_len = 11'd16;
    for (int i = 0; i < 16; i++) beat_buf[i] = 16'((i * 53 + 9) & 8'hff);
    auto_bp = 1;
    play(3, 16, 16, "R10 backpressure 8bpp");
    drain();
    auto_bp = 0;
    @(posedge clk); #1;
    out_ready = 1'b1;

    // R11: write index 5 in the cycle its lookup happens
    line_len = 11'd3;
    out_ready = 1'b0;
    push_exp(m_444(pal_m[5][11:0]), 1'b0, "R11 old value first");
    send_beat(16'h0005);
    push_exp(m_444(pal_m[5][11:0]), 1'b0, "R11 old value on write cycle");
    send_beat(16'h0005);
    pal_we = 1'b1; pal_widx = 8'd5; pal_wdata = 16'h0c3a;
    out_ready = 1'b1;
    @(posedge clk); #1;
    pal_we = 1'b0;
    pal_m[5] = 16'h0c3a;
    push_exp(m_444(12'hc3a), 1'b1, "R11 new value after write");
    send_beat(16'h0005);
    drain();

    done = 1;
    report();
  end

endmodule